// File: doc/BRIEF.md
# Nested Interrupt Level Mask Unit

This block is the acceptance stage on the processor side of an interrupt path. An interrupt controller presents a single pending request as a 3-bit level with a valid strobe. The unit compares that level with a current mask level kept in a status register. When the request clears the mask, the unit emits a one-cycle accept pulse. In the same step it raises the mask to one above the accepted level and saves the old mask on a small hardware stack.

A return strobe pops the saved mask and puts it back in force. Handlers can therefore nest: while a handler runs, only requests at or above the raised mask get through. Software can load the mask directly through a write port. Level 7 is the non-maskable level, and it always gets through. The mask comes out of reset at 7, so nothing maskable is taken until software lowers it.

The save stack holds eight entries. An acceptance that finds the stack full is still taken, but the old mask is dropped and a sticky overflow flag is raised.

Top module: `nest_mask_unit`

## Requirements
- R1: After reset, mask_o is 7, accept_o is 0, ovf_err_o is 0 and the save stack is empty.
- R2: A request is accepted in a cycle where req_valid_i is 1, ret_i is 0 and req_level_i >= mask_o. accept_o is then 1 for exactly the following cycle. In every other case accept_o is 0.
- R3: After an acceptance, mask_o equals the accepted level plus one, saturating at 7 (accepted level 7 gives mask 7).
- R4: On acceptance the mask in force before it is pushed on the save stack. A return pops the most recent entry into mask_o, so nested handlers unwind in last-in first-out order.
- R5: A request at level 7 is accepted whatever the mask value, unless a return is given in the same cycle.
- R6: A return while the save stack is empty changes nothing: mask_o keeps its value.
- R7: In a cycle with ret_i = 1 no request is accepted, and the pending request has no effect on the mask.
- R8: mask_we_i loads mask_wdata_i into the mask. This happens only in a cycle with no return and no acceptance; otherwise the write is ignored.
- R9: An acceptance while eight entries are saved still raises the mask but discards the save. ovf_err_o is set and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is presented |
| req_level_i | input | 3 | Level of the presented request |
| ret_i | input | 1 | Return-from-handler strobe |
| mask_we_i | input | 1 | Software mask write enable |
| mask_wdata_i | input | 3 | Software mask write value |
| accept_o | output | 1 | One-cycle pulse for an accepted request |
| mask_o | output | 3 | Current mask level |
| ovf_err_o | output | 1 | Sticky save-stack overflow flag |

## Verification
The comparison is exercised at several points. A request one below the mask must be rejected and one equal to the mask accepted, which separates the >= test from a strict greater-than test. Level 7 is sent at mask 7 to tell saturation apart from wraparound. Two nested accepts followed by two returns expose any stack ordering that is not last-in first-out. Collisions of a return or a software write with a live request show the priority between the three mask sources. A nine-deep nest and nine returns cover overflow and the empty-stack return. A long random stretch is then compared against the behavioural model on every clock.

// File: rtl/nmu_pkg.sv
package nmu_pkg;
  localparam int unsigned LVL_W_DEF = 3;
  localparam int unsigned DEPTH_DEF = 8;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_POP  = 2'd1,
    SRC_ACC  = 2'd2,
    SRC_SW   = 2'd3
  } mask_src_e;
endpackage

// File: rtl/nmu_gate.sv
module nmu_gate #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             req_valid_i,
  input  logic [LVL_W-1:0] req_level_i,
  input  logic             ret_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             acc_o,
  output logic [LVL_W-1:0] raised_o
);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};

  assign acc_o    = req_valid_i && !ret_i && (req_level_i >= mask_i);
  // saturate instead of wrapping at the top level
  assign raised_o = (req_level_i == MAX_LVL) ? MAX_LVL : req_level_i + LVL_W'(1);
endmodule

// File: rtl/nmu_lifo.sv
module nmu_lifo #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     mem_q [DEPTH];

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (push_i && !full_o && (cnt_q == CNT_W'(i))) begin
        mem_q[i] <= push_data_i;
      end
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_o = mem_q[i];
    end
  end
endmodule

// File: rtl/nest_mask_unit.sv
module nest_mask_unit
  import nmu_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LVL_W-1:0] req_level_i,
  input  logic             ret_i,
  input  logic             mask_we_i,
  input  logic [LVL_W-1:0] mask_wdata_i,
  output logic             accept_o,
  output logic [LVL_W-1:0] mask_o,
  output logic             ovf_err_o
);
  localparam logic [LVL_W-1:0] MASK_RST = {LVL_W{1'b1}};

  logic             acc;
  logic [LVL_W-1:0] raised;
  logic [LVL_W-1:0] top;
  logic             empty, full;
  logic             pop;
  logic [LVL_W-1:0] mask_q, mask_d;
  logic             acc_q, err_q;
  mask_src_e        src;

  nmu_gate #(.LVL_W(LVL_W)) u_gate (
    .req_valid_i (req_valid_i),
    .req_level_i (req_level_i),
    .ret_i       (ret_i),
    .mask_i      (mask_q),
    .acc_o       (acc),
    .raised_o    (raised)
  );

  assign pop = ret_i && !empty;

  nmu_lifo #(.W(LVL_W), .DEPTH(DEPTH)) u_lifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (acc),
    .push_data_i (mask_q),
    .pop_i       (pop),
    .top_o       (top),
    .empty_o     (empty),
    .full_o      (full)
  );

  // return beats acceptance beats software write
  always_comb begin
    if (ret_i)          src = pop ? SRC_POP : SRC_HOLD;
    else if (acc)       src = SRC_ACC;
    else if (mask_we_i) src = SRC_SW;
    else                src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_POP: mask_d = top;
      SRC_ACC: mask_d = raised;
      SRC_SW:  mask_d = mask_wdata_i;
      default: mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_RST;
      acc_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      acc_q  <= acc;
      if (acc && full) err_q <= 1'b1;
    end
  end

  assign accept_o  = acc_q;
  assign mask_o    = mask_q;
  assign ovf_err_o = err_q;
endmodule

// File: rtl/nest_mask_unit_chk.sv
module nest_mask_unit_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [LVL_W-1:0] req_level_i,
  input logic             ret_i,
  input logic             mask_we_i,
  input logic [LVL_W-1:0] mask_wdata_i,
  input logic             accept_o,
  input logic [LVL_W-1:0] mask_o,
  input logic             ovf_err_o
);
  localparam logic [LVL_W-1:0] MAXL = {LVL_W{1'b1}};

  logic             acc_now;
  logic [LVL_W-1:0] exp_raise;
  assign acc_now   = req_valid_i && !ret_i && (req_level_i >= mask_o);
  assign exp_raise = (req_level_i == MAXL) ? MAXL : req_level_i + LVL_W'(1);

  // R2
  a_r2_accept_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(acc_now));
  // R3
  a_r3_raise_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_now |=> (mask_o == $past(exp_raise)));
  // R5
  a_r5_top_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ret_i && req_level_i == MAXL) |=> accept_o);
  // R7
  a_r7_no_acc_on_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> !accept_o);
  // R8
  a_r8_sw_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && !ret_i && !acc_now) |=> (mask_o == $past(mask_wdata_i)));
  // R9
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);
endmodule

bind nest_mask_unit nest_mask_unit_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_level_i  (req_level_i),
  .ret_i        (ret_i),
  .mask_we_i    (mask_we_i),
  .mask_wdata_i (mask_wdata_i),
  .accept_o     (accept_o),
  .mask_o       (mask_o),
  .ovf_err_o    (ovf_err_o)
);

// File: tb/nest_mask_unit_tb.sv
module nest_mask_unit_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_level_i = '0;
  logic       ret_i = 1'b0;
  logic       mask_we_i = 1'b0;
  logic [2:0] mask_wdata_i = '0;
  logic       accept_o;
  logic [2:0] mask_o;
  logic       ovf_err_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  int m_mask = 7;
  int m_stk[$];
  bit m_err = 0;
  bit m_acc = 0;

  always #5 clk = ~clk;

  nest_mask_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_level_i(req_level_i),
    .ret_i(ret_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .accept_o(accept_o), .mask_o(mask_o), .ovf_err_o(ovf_err_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "accept_o", int'(accept_o), int'(m_acc));
    chk(tag, "mask_o", int'(mask_o), m_mask);
    chk(tag, "ovf_err_o", int'(ovf_err_o), int'(m_err));
  endtask

  task automatic step(string tag, bit v, int l, bit r, bit we, int wd);
    bit a;
    req_valid_i = v; req_level_i = 3'(l); ret_i = r;
    mask_we_i = we; mask_wdata_i = 3'(wd);
    @(posedge clk);
    a = !r && v && (l >= m_mask);
    if (r) begin
      if (m_stk.size() > 0) m_mask = m_stk.pop_back();
    end else if (a) begin
      if (m_stk.size() < 8) m_stk.push_back(m_mask);
      else m_err = 1;
      m_mask = (l + 1 > 7) ? 7 : l + 1;
    end else if (we) begin
      m_mask = wd;
    end
    m_acc = a;
    #1;
    cmp_all(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R1");
    rst_ni = 1'b1;
    @(posedge clk); #1;
    cmp_all("R1");

    step("R2", 1, 6, 0, 0, 0);        // 6 < 7: rejected
    step("R5", 1, 7, 0, 0, 0);        // top level accepted at mask 7
    step("R3", 0, 0, 0, 0, 0);        // mask saturates at 7
    step("R4", 0, 0, 1, 0, 0);        // restore 7
    step("R6", 0, 0, 1, 0, 0);        // empty: no change
    step("R8", 0, 0, 0, 1, 2);        // mask <- 2
    step("R2", 1, 1, 0, 0, 0);        // below mask
    step("R2", 1, 2, 0, 0, 0);        // equal: accepted, mask 3
    step("R4", 1, 3, 0, 0, 0);        // nested, mask 4
    step("R2", 1, 3, 0, 0, 0);        // 3 < 4 rejected
    step("R4", 0, 0, 1, 0, 0);        // back to 3
    step("R4", 0, 0, 1, 0, 0);        // back to 2
    step("R7", 1, 7, 1, 0, 0);        // return on empty with request: nothing
    idle("R7");
    step("R8", 1, 5, 0, 1, 0);        // accept beats write, mask 6
    step("R8", 0, 0, 1, 1, 1);        // ret beats write, mask 2
    step("R8", 0, 0, 0, 1, 0);        // mask 0

    for (int i = 0; i < 9; i++) step("R9", 1, 7, 0, 0, 0);
    idle("R9");
    for (int i = 0; i < 9; i++) step("R9", 0, 0, 1, 0, 0);
    step("R6", 0, 0, 1, 0, 0);

    // reset clears error, then random traffic
    rst_ni = 1'b0;
    m_mask = 7; m_stk.delete(); m_err = 0; m_acc = 0;
    #1;
    cmp_all("R1");
    @(posedge clk); #1;
    rst_ni = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      step("R2", ($urandom % 3) != 0, $urandom % 8, ($urandom % 4) == 0,
           ($urandom % 5) == 0, $urandom % 8);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule